// File: doc/BRIEF.md
# Channel-Selectable Block FIR with Distributed Arithmetic

This block is a multiplier-free FIR filter for a digital channelizer. Each accepted transfer carries a block of L consecutive input samples. The block returns L filtered outputs, one for each sample position. It keeps a fixed set of coefficient banks, one per channel, each with a different passband width. A channel index given with the block picks the bank that filters it.

Inner products are computed with distributed arithmetic over the sample bits, least significant bit first. Each bit cycle reads small offset-binary partial-sum tables, and the table outputs are shifted and accumulated. Each table covers a group of taps and stores only half of its address space: the other half is recovered by complementing the address and negating the entry. The L outputs share one sample window and one set of table contents. A constant correction term seeds each accumulator, and the final value is halved to give a full-precision result.

The engine is busy for W bit cycles per block. It signals when it can take a new block, and it raises a one-cycle valid pulse when the L results are ready.

Top module: `blk_da_fir`

## Requirements
- R1: Each output y equals the exact sum over taps k=0..NTAPS-1 of h[k]·x[n-k], in two's complement with no rounding. The output word is 2·W+log2(NTAPS) bits wide (35 bits by default).
- R2: `dataIn` packs element i at bits [i·W +: W], and element 0 is the oldest sample of the block. `yOut` packs the result for element i at bits [i·YW +: YW].
- R3: With NTAPS=8, let m=min(k,7-k). The coefficient banks are: channel 0, h=4096·(m+1); channel 1, h=8191·(m+1); channel 2, h=(+2000 for even k, -2000 for odd k)·(m+1); channel 3, h=-32768 when m=3 and 5000·m-7000 otherwise. The 2-bit `chSel` is sampled on the cycle a block is accepted.
- R4: Changing `chSel` while a block is being processed has no effect on that block's results.
- R5: A block is accepted on a rising edge with `inValid` and `inReady` both high. `outValid` is high for exactly one cycle, starting W (16) rising edges after the accepting edge, and is low on the cycle that follows.
- R6: `inReady` is low from the cycle after acceptance until results are delivered. `inValid` while `inReady` is low is ignored, and those samples never enter the delay line.
- R7: Synchronous reset drives `outValid` low and `inReady` high, and clears the sample history to zero.
- R8: The delay line carries the last NTAPS-1 samples across blocks, so the output stream equals that of a single-sample FIR fed the concatenated input.
- R9: Inputs of -32768 on every tap, with any bank, give exact results with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A sample block is offered |
| inReady | output | 1 | Engine idle; a block offered now is accepted |
| chSel | input | 2 | Coefficient bank index |
| dataIn | input | L·W (32) | Sample block, element 0 oldest |
| outValid | output | 1 | One-cycle pulse, results present |
| yOut | output | L·YW (70) | Result block, element i in slice i |

## Verification
Impulse blocks on every channel bring out each bank's taps in order. This separates coefficient, tap-order and element-packing faults. Random blocks on all channels, sent back to back, test history continuity and the sign handling of the bit-serial sum. Blocks of all -32768 exercise the sign-bit subtraction and the full output width. Channel switches between blocks, channel changes in the middle of a block, and blocks offered while busy separate the cases where a bank or sample is latched correctly from those where it leaks into the block in progress.

// File: rtl/blk_da_fir_pkg.sv
package blk_da_fir_pkg;

  typedef struct packed {
    logic       load;
    logic       step;
    logic       signBit;
    logic       last;
    logic [7:0] bitIdx;
  } ctrlStrobe_t;

  // bank coefficient for channel ch, tap k
  function automatic int coefVal(input int ch, input int k, input int ntaps);
    int m;
    m = (k < ntaps - 1 - k) ? k : ntaps - 1 - k;
    case (ch % 4)
      0: return 4096 * (m + 1);
      1: return 8191 * (m + 1);
      2: return (((k % 2) == 0) ? 2000 : -2000) * (m + 1);
      default: return (m == ntaps / 2 - 1) ? -32768 : 5000 * m - 7000;
    endcase
  endfunction

  // offset-binary partial sum: each address bit weights its tap by +1 or -1
  function automatic int entryVal(input int ch, input int sidx, input int a,
                                  input int subn, input int ntaps);
    int s;
    s = 0;
    for (int t = 0; t < subn; t++) begin
      if (((a >> t) & 1) == 1) s = s + coefVal(ch, sidx * subn + t, ntaps);
      else                     s = s - coefVal(ch, sidx * subn + t, ntaps);
    end
    return s;
  endfunction

  function automatic longint coefSum(input int ch, input int ntaps);
    longint s;
    s = 0;
    for (int k = 0; k < ntaps; k++) s = s + longint'(coefVal(ch, k, ntaps));
    return s;
  endfunction

endpackage

// File: rtl/blk_da_fir_lut.sv
module blk_da_fir_lut
  import blk_da_fir_pkg::*;
#(
  parameter int W     = 16,
  parameter int SUBN  = 4,
  parameter int NTAPS = 8,
  parameter int NCH   = 4,
  parameter int SIDX  = 0,
  parameter int CHW   = 2,
  parameter int TW    = 19
) (
  input  logic [CHW-1:0]       chan,
  input  logic [SUBN-1:0]      addr,
  output logic signed [TW-1:0] partial
);
  localparam int HALF = 2 ** (SUBN - 1);

  logic signed [TW-1:0] rom [NCH][HALF];

  for (genvar gc = 0; gc < NCH; gc++) begin : g_chan
    for (genvar ga = 0; ga < HALF; ga++) begin : g_entry
      localparam int ENTRY = entryVal(gc, SIDX, ga, SUBN, NTAPS);
      assign rom[gc][ga] = TW'(ENTRY);
    end
  end

  logic                 topBit;
  logic [SUBN-2:0]      lowAddr;
  logic signed [TW-1:0] rawVal;

  always_comb begin
    topBit  = addr[SUBN-1];
    lowAddr = topBit ? ~addr[SUBN-2:0] : addr[SUBN-2:0];
    rawVal  = rom[chan][lowAddr];
    partial = topBit ? -rawVal : rawVal;
  end

endmodule

// File: rtl/blk_da_fir_ctrl.sv
module blk_da_fir_ctrl
  import blk_da_fir_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  output ctrlStrobe_t strobe
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t     state;
  logic [7:0] bitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (inValid) begin
          state  <= S_RUN;
          bitCnt <= '0;
        end
        default: begin
          if (bitCnt == 8'(W - 1)) state <= S_IDLE;
          else bitCnt <= bitCnt + 8'd1;
        end
      endcase
    end
  end

  always_comb begin
    inReady        = (state == S_IDLE);
    strobe.load    = inValid && (state == S_IDLE);
    strobe.step    = (state == S_RUN);
    strobe.bitIdx  = bitCnt;
    strobe.signBit = (state == S_RUN) && (bitCnt == 8'(W - 1));
    strobe.last    = (state == S_RUN) && (bitCnt == 8'(W - 1));
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady); // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    strobe.step |-> (strobe.bitIdx < 8'(W))); // R5

endmodule

// File: rtl/blk_da_fir_dpath.sv
module blk_da_fir_dpath
  import blk_da_fir_pkg::*;
#(
  parameter int W     = 16,
  parameter int L     = 2,
  parameter int NTAPS = 8,
  parameter int NCH   = 4,
  parameter int SUBN  = 4,
  parameter int CHW   = 2,
  parameter int YW    = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [CHW-1:0]    chSel,
  input  logic [L*W-1:0]    dataIn,
  output logic              outValid,
  output logic [L*YW-1:0]   yOut
);
  localparam int NWIN = NTAPS + L - 1;
  localparam int NHIS = NTAPS - 1;
  localparam int NSUB = NTAPS / SUBN;
  localparam int TW   = W + $clog2(SUBN) + 1;
  localparam int ACCW = YW + 2;

  logic [W-1:0]           hist    [NHIS];
  logic [W-1:0]           win     [NWIN];
  logic [W-1:0]           full    [NWIN];
  logic [CHW-1:0]         chLatch;
  logic signed [ACCW-1:0] acc     [L];
  logic signed [ACCW-1:0] accNext [L];
  logic signed [ACCW-1:0] hNeg    [NCH];
  logic signed [TW-1:0]   partial [L][NSUB];
  logic [SUBN-1:0]        lutAddr [L][NSUB];

  // correction seed per bank: minus the coefficient sum (doubled domain)
  for (genvar gc = 0; gc < NCH; gc++) begin : g_seed
    localparam longint HSUM = coefSum(gc, NTAPS);
    assign hNeg[gc] = -ACCW'(HSUM);
  end

  // window assembled from history plus the incoming block
  always_comb begin
    for (int m = 0; m < NWIN; m++) begin
      if (m < NHIS) full[m] = hist[m];
      else          full[m] = dataIn[(m - NHIS) * W +: W];
    end
  end

  // table addressing: output i, sub-table s, bit t reads tap s*SUBN+t
  for (genvar gi = 0; gi < L; gi++) begin : g_out
    for (genvar gs = 0; gs < NSUB; gs++) begin : g_sub
      for (genvar gt = 0; gt < SUBN; gt++) begin : g_bit
        assign lutAddr[gi][gs][gt] = win[NTAPS - 1 + gi - (gs * SUBN + gt)][0];
      end
      blk_da_fir_lut #(
        .W(W), .SUBN(SUBN), .NTAPS(NTAPS), .NCH(NCH),
        .SIDX(gs), .CHW(CHW), .TW(TW)
      ) u_lut (
        .chan    (chLatch),
        .addr    (lutAddr[gi][gs]),
        .partial (partial[gi][gs])
      );
    end
  end

  logic signed [ACCW-1:0] sumD [L];
  logic signed [ACCW-1:0] term [L];

  always_comb begin
    for (int i = 0; i < L; i++) begin
      sumD[i] = '0;
      for (int s = 0; s < NSUB; s++) sumD[i] = sumD[i] + ACCW'(partial[i][s]);
      term[i]    = sumD[i] <<< strobe.bitIdx;
      accNext[i] = strobe.signBit ? (acc[i] - term[i]) : (acc[i] + term[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      chLatch  <= '0;
      yOut     <= '0;
      for (int m = 0; m < NHIS; m++) hist[m] <= '0;
      for (int m = 0; m < NWIN; m++) win[m]  <= '0;
      for (int i = 0; i < L; i++)    acc[i]  <= '0;
    end else begin
      outValid <= strobe.step && strobe.last;
      if (strobe.load) begin
        chLatch <= chSel;
        for (int m = 0; m < NWIN; m++) win[m]  <= full[m];
        for (int m = 0; m < NHIS; m++) hist[m] <= full[m + L];
        for (int i = 0; i < L; i++)    acc[i]  <= hNeg[chSel];
      end else if (strobe.step) begin
        for (int m = 0; m < NWIN; m++) win[m] <= win[m] >> 1;
        for (int i = 0; i < L; i++)    acc[i] <= accNext[i];
        if (strobe.last) begin
          for (int i = 0; i < L; i++) yOut[i * YW +: YW] <= YW'(accNext[i] >>> 1);
        end
      end
    end
  end

  for (genvar gi = 0; gi < L; gi++) begin : g_chk
    AST_OBC_EVEN: assert property (@(posedge clk) disable iff (rst)
      (strobe.step && strobe.last) |-> (accNext[gi][0] == 1'b0)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (strobe.step && strobe.last) |->
        ((accNext[gi][ACCW-1:YW] == '0 && !accNext[gi][YW]) ||
         (accNext[gi][ACCW-1:YW] == '1 &&  accNext[gi][YW]))); // R9
  end

  AST_CH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !strobe.last) |=> $stable(chLatch)); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid); // R5

endmodule

// File: rtl/blk_da_fir.sv
module blk_da_fir
  import blk_da_fir_pkg::*;
#(
  parameter  int W     = 16,
  parameter  int L     = 2,
  parameter  int NTAPS = 8,
  parameter  int NCH   = 4,
  parameter  int SUBN  = 4,
  localparam int CHW   = $clog2(NCH),
  localparam int YW    = 2 * W + $clog2(NTAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output logic            inReady,
  input  logic [CHW-1:0]  chSel,
  input  logic [L*W-1:0]  dataIn,
  output logic            outValid,
  output logic [L*YW-1:0] yOut
);
  ctrlStrobe_t strobe;

  blk_da_fir_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .strobe  (strobe)
  );

  blk_da_fir_dpath #(
    .W(W), .L(L), .NTAPS(NTAPS), .NCH(NCH), .SUBN(SUBN), .CHW(CHW), .YW(YW)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .chSel    (chSel),
    .dataIn   (dataIn),
    .outValid (outValid),
    .yOut     (yOut)
  );

endmodule

// File: tb/blk_da_fir_bench.sv
module blk_da_fir_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int L  = 2;
  localparam int NT = 8;
  localparam int YW = 35;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic            inReady;
  logic [1:0]      chSel = '0;
  logic [L*W-1:0]  dataIn = '0;
  logic            outValid;
  logic [L*YW-1:0] yOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic signed [15:0] bh [0:NT-2];

  always #(CLK_PERIOD / 2) clk = ~clk;

  blk_da_fir u_blk_da_fir (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .chSel(chSel), .dataIn(dataIn), .outValid(outValid), .yOut(yOut)
  );

  function automatic longint hRef(int ch, int k);
    int m;
    m = (k < 7 - k) ? k : 7 - k;
    case (ch)
      0: return longint'(4096 * (m + 1));
      1: return longint'(8191 * (m + 1));
      2: return longint'((((k % 2) == 0) ? 2000 : -2000) * (m + 1));
      default: return (m == 3) ? -32768 : longint'(5000 * m - 7000);
    endcase
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runBlock(int ch, int a, int b, string req, bit wiggle, bit poke);
    logic signed [15:0] fullS [0:NT+L-2];
    longint exp [L];
    int lat;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    for (int m = 0; m < NT - 1; m++) fullS[m] = bh[m];
    fullS[NT-1] = 16'(a);
    fullS[NT]   = 16'(b);
    for (int i = 0; i < L; i++) begin
      exp[i] = 0;
      for (int k = 0; k < NT; k++)
        exp[i] += hRef(ch, k) * longint'(fullS[NT - 1 + i - k]);
    end
    inValid = 1'b1;
    chSel   = 2'(ch);
    dataIn  = {16'(b), 16'(a)};
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    dataIn  = 32'h5A5A_A5A5;
    lat = 0;
    while (lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (outValid) break;
      if (wiggle) chSel = 2'(ch + lat);
      if (poke && lat == 3) begin
        chk("R6 busy ready", longint'(inReady), 0);
        inValid = 1'b1;
        dataIn  = {16'h7FFF, 16'h7FFF};
      end
      if (poke && lat == 4) inValid = 1'b0;
    end
    chk({"R5 latency ", req}, longint'(lat), 16);
    for (int i = 0; i < L; i++)
      chk({"R1 R2 ", req}, longint'($signed(yOut[i*YW +: YW])), exp[i]);
    for (int m = 0; m < NT - 1; m++) bh[m] = fullS[m + L];
    chSel = 2'(ch);
    @(posedge clk);
    @(negedge clk);
    chk("R5 pulse width", longint'(outValid), 0);
  endtask

  task automatic testReset();
    chk("R7 ready after reset", longint'(inReady), 1);
    chk("R7 valid after reset", longint'(outValid), 0);
  endtask

  task automatic testImpulse();
    for (int ch = 0; ch < 4; ch++) begin
      runBlock(ch, 1, 0, (ch == 0) ? "R7 R3 impulse" : "R3 impulse", 0, 0);
      for (int n = 0; n < 4; n++) runBlock(ch, 0, 0, "R3 impulse tail", 0, 0);
    end
  endtask

  task automatic testRandom();
    for (int ch = 0; ch < 4; ch++)
      for (int n = 0; n < 4; n++)
        runBlock(ch, int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                 "R8 random", 0, 0);
  endtask

  task automatic testExtreme();
    for (int n = 0; n < 5; n++) runBlock(3, -32768, -32768, "R9 min ch3", 0, 0);
    for (int n = 0; n < 5; n++) runBlock(1, -32768, -32768, "R9 min ch1", 0, 0);
    for (int n = 0; n < 5; n++) runBlock(1, 32767, -32768, "R9 mixed ch1", 0, 0);
  endtask

  task automatic testSwitch();
    for (int n = 0; n < 8; n++)
      runBlock(n % 4, 1000 * n - 3000, -777 * n, "R3 switch", 0, 0);
  endtask

  task automatic testMidChange();
    for (int n = 0; n < 4; n++)
      runBlock(n, 12345 - 4000 * n, -20000 + 9000 * n, "R4 mid change", 1, 0);
  endtask

  task automatic testBusyPoke();
    for (int n = 0; n < 3; n++)
      runBlock(2, 300 * n + 5, -31000, "R6 poke", 0, 1);
    runBlock(2, 0, 0, "R6 history clean", 0, 0);
  endtask

  initial begin
    for (int m = 0; m < NT - 1; m++) bh[m] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testImpulse();
    testRandom();
    testExtreme();
    testSwitch();
    testMidChange();
    testBusyPoke();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule